// File: doc/BRIEF.md
# LED Channel Soft-Start Sequencer

This block runs the per-channel turn-on sequence of a multi-channel LED driver. Each channel sits idle until software enables it with a usable current setting. It then waits for the compensation node and the dimming input to be ready. After that it drives a soft-start DAC code upward, one step per clock, but only while the PWM dimming input is high. When the code reaches full scale the channel is held steadily on.

Faults come in two kinds. A latched fault drops the channel back to idle, requests that the enable bit be cleared, and asks for the compensation pin to be pulled low. A non-latched fault returns a ramping or running channel to readiness checking, and the channel waits there until the fault goes away. A mode pin blocks normal operation while it is high.

A small shared fault status word records faults and a power-cycle flag, and reading it clears it. Sticky fault-pin outputs stay set until a reset strobe is written. Ramp codes, status and fault pins all come from registers, so every result shows up one clock edge after the inputs that cause it.

Top module: `ledss_top`

## Requirements
- R1: Synchronous reset (`rst` high) puts every channel in a reset state for which `dac_code`, `ch_on`, `ramp_done`, `comp_pull_low`, `en_clr_req` and `fault_pin` are all 0. On the status word it sets only bit 0, the power-cycle flag. On the first edge after release the channel enters idle.
- R2: An idle channel moves to readiness checking only on an edge where its enable is 1, `mode_hi` is 0, and its current-adjust code is strictly greater than 8. With a code of exactly 8, or with `mode_hi` high, it stays idle.
- R3: A checking channel starts ramping (`ch_on` becomes 1, `dac_code` 0) on the edge where `comp_low`, `pwm` and a current-adjust code above 8 are all present together. Otherwise it keeps waiting.
- R4: While ramping, `dac_code` rises by exactly one on each edge where `pwm` is 1. It holds its value on each edge where `pwm` is 0.
- R5: The edge that brings `dac_code` to full scale (2^DAC_W-1, which is 63 by default) also puts the channel in steady on. There `ramp_done` and `ch_on` are 1 and the code stays at full scale.
- R6: A latched fault seen while checking, ramping or on returns the channel to idle on the next edge. On that edge `ch_on` and `dac_code` become 0, `comp_pull_low` becomes 1, and `en_clr_req` pulses high for exactly one cycle. `comp_pull_low` stays high until the channel next starts ramping.
- R7: A non-latched fault while checking holds the channel there, with no ramp start and no pull-low. The ramp can start on the first edge after the fault is removed.
- R8: A non-latched fault while ramping or on turns the channel off and zeroes its code on the next edge. It also sets `comp_pull_low` without pulsing `en_clr_req`, and leaves the channel in readiness checking.
- R9: When both fault kinds are present at once, the latched-fault behaviour of R6 applies.
- R10: An enable of 0, or `mode_hi` at 1, with no latched fault, returns an active channel to idle on the next edge, with `ch_on`, `ramp_done` and `dac_code` at 0.
- R11: Status word layout: bit 0 is the power-cycle flag, bit 1+2c is the latched-fault bit of channel c, and bit 2+2c is the non-latched-fault bit of channel c. A fault input sets its bit on the next edge, in any state. A `stat_rd` strobe clears the whole word on the next edge, except for bits set by faults present in that same cycle.
- R12: `fault_pin[c]` becomes 1 on the edge after any fault on channel c. It clears only on the edge after a `fpin_rst` strobe, and a fault present in that cycle wins.
- R13: Channels are independent, and a fault on an idle channel neither affects another channel nor raises `en_clr_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mode_hi | input | 1 | Mode pin; high blocks normal operation |
| ch_en | input | NUM_CH | Per-channel enable register bit |
| iadj | input | NUM_CH*IADJ_W | Per-channel current-adjust code, channel c at [c*IADJ_W +: IADJ_W] |
| comp_low | input | NUM_CH | Compensation-low ready status |
| pwm | input | NUM_CH | PWM dimming input |
| flt_lat | input | NUM_CH | Latched fault flag |
| flt_nl | input | NUM_CH | Non-latched fault flag |
| stat_rd | input | 1 | Status read strobe (read-to-clear) |
| fpin_rst | input | 1 | Fault-pin reset strobe |
| dac_code | output | NUM_CH*DAC_W | Soft-start ramp DAC code per channel |
| ch_on | output | NUM_CH | Channel driving (ramping or steady on) |
| ramp_done | output | NUM_CH | Ramp reached full scale |
| comp_pull_low | output | NUM_CH | Compensation pin pull-low request |
| en_clr_req | output | NUM_CH | One-cycle request to clear the enable bit |
| fault_pin | output | NUM_CH | Sticky fault pin |
| stat_rdata | output | 2*NUM_CH+1 | Fault status word |

## Verification
All outputs come from registers. A single-step result (ramp step, fault reaction, status set or clear, pin set or clear) is therefore due on the first rising edge after the stimulus is applied. A move from idle to ramping takes two edges: idle to checking, then checking to ramping. The bench changes inputs 1 ns after an edge and reads outputs 1 ns after the following edge, so each check falls on the edge where its result is due. It uses the edge count to tell states apart at the ports. A channel that went back to idle shows `ch_on` two edges after ramp conditions are applied. A channel that stayed in checking shows it after one.

// File: rtl/ledss_pkg.sv
package ledss_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_IDLE  = 3'd1,
        ST_CHECK = 3'd2,
        ST_RAMP  = 3'd3,
        ST_ON    = 3'd4
    } ledss_state_e;

    typedef struct packed {
        logic on;
        logic done;
        logic pull_low;
        logic clr_req;
    } ledss_flags_t;

    function automatic logic code_above(input int unsigned code, input int unsigned lim);
        return code > lim;
    endfunction

    function automatic logic is_active(input ledss_state_e s);
        return (s == ST_CHECK) || (s == ST_RAMP) || (s == ST_ON);
    endfunction

    function automatic logic is_driving(input ledss_state_e s);
        return (s == ST_RAMP) || (s == ST_ON);
    endfunction

endpackage

// File: rtl/ledss_ramp.sv
module ledss_ramp #(
    parameter int DAC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [DAC_W-1:0] code,
    output logic             last
);
    localparam logic [DAC_W-1:0] FULL = '1;
    localparam logic [DAC_W-1:0] NEAR = {{(DAC_W-1){1'b1}}, 1'b0};

    logic [DAC_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code_q <= '0;
        end else if (inc && code_q != FULL) begin
            code_q <= code_q + 1'b1;
        end
    end

    assign code = code_q;
    assign last = (code_q == NEAR);

    // R4
    code_step_chk: assert property (@(posedge clk) disable iff (rst)
        (code_q != $past(code_q)) |-> (code_q == '0 || code_q == $past(code_q) + 1'b1));

endmodule

// File: rtl/ledss_fsm.sv
module ledss_fsm
    import ledss_pkg::*;
#(
    parameter int IADJ_W   = 4,
    parameter int IADJ_MIN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_hi,
    input  logic              ch_en,
    input  logic [IADJ_W-1:0] iadj,
    input  logic              comp_low,
    input  logic              pwm,
    input  logic              flt_lat,
    input  logic              flt_nl,
    input  logic              ramp_last,
    output logic              ramp_clr,
    output logic              ramp_inc,
    output ledss_flags_t      flags
);
    ledss_state_e state_q, state_d;
    logic pull_low_q, clr_req_q;
    logic set_pl, clr_pl, req_d;
    logic run_ok, iadj_ok;

    assign run_ok  = ch_en && !mode_hi;
    assign iadj_ok = code_above(32'(iadj), IADJ_MIN);

    always_comb begin
        state_d  = state_q;
        ramp_clr = 1'b0;
        ramp_inc = 1'b0;
        set_pl   = 1'b0;
        clr_pl   = 1'b0;
        req_d    = 1'b0;
        unique case (state_q)
            ST_RESET: begin
                state_d  = ST_IDLE;
                ramp_clr = 1'b1;
            end
            ST_IDLE: begin
                ramp_clr = 1'b1;
                if (run_ok && iadj_ok) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                ramp_clr = 1'b1;
                if (flt_lat) begin
                    state_d = ST_IDLE;
                    set_pl  = 1'b1;
                    req_d   = 1'b1;
                end else if (!run_ok) begin
                    state_d = ST_IDLE;
                end else if (!flt_nl && comp_low && pwm && iadj_ok) begin
                    state_d = ST_RAMP;
                    clr_pl  = 1'b1;
                end
            end
            ST_RAMP, ST_ON: begin
                if (flt_lat) begin
                    state_d  = ST_IDLE;
                    ramp_clr = 1'b1;
                    set_pl   = 1'b1;
                    req_d    = 1'b1;
                end else if (!run_ok) begin
                    state_d  = ST_IDLE;
                    ramp_clr = 1'b1;
                end else if (flt_nl) begin
                    state_d  = ST_CHECK;
                    ramp_clr = 1'b1;
                    set_pl   = 1'b1;
                end else if (state_q == ST_RAMP && pwm) begin
                    ramp_inc = 1'b1;
                    if (ramp_last) state_d = ST_ON;
                end
            end
            default: begin
                state_d  = ST_IDLE;
                ramp_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RESET;
            pull_low_q <= 1'b0;
            clr_req_q  <= 1'b0;
        end else begin
            state_q    <= state_d;
            clr_req_q  <= req_d;
            if (set_pl)      pull_low_q <= 1'b1;
            else if (clr_pl) pull_low_q <= 1'b0;
        end
    end

    assign flags.on       = is_driving(state_q);
    assign flags.done     = (state_q == ST_ON);
    assign flags.pull_low = pull_low_q;
    assign flags.clr_req  = clr_req_q;

    // R6
    lat_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (is_active(state_q) && flt_lat) |=> (clr_req_q && pull_low_q && state_q == ST_IDLE));

    // R7
    nl_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && flt_nl && !flt_lat && run_ok) |=> (state_q == ST_CHECK && !flags.on));

    // R8
    nl_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (is_driving(state_q) && flt_nl && !flt_lat && run_ok) |=> (state_q == ST_CHECK && pull_low_q && !clr_req_q));

    // R10
    stop_chk: assert property (@(posedge clk) disable iff (rst)
        (is_active(state_q) && !run_ok && !flt_lat) |=> (state_q == ST_IDLE && !flags.on));

    // R2
    mode_block_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && mode_hi) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/ledss_fault_reg.sv
module ledss_fault_reg #(
    parameter int NUM_CH = 2,
    localparam int STAT_W = 2 * NUM_CH + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] flt_lat,
    input  logic [NUM_CH-1:0] flt_nl,
    input  logic              stat_rd,
    input  logic              fpin_rst,
    output logic [STAT_W-1:0] stat_rdata,
    output logic [NUM_CH-1:0] fault_pin
);
    logic [STAT_W-1:0] stat_q, stat_set;
    logic [NUM_CH-1:0] pin_q;

    assign stat_set[0] = 1'b0;
    for (genvar c = 0; c < NUM_CH; c++) begin : g_map
        assign stat_set[1 + 2*c] = flt_lat[c];
        assign stat_set[2 + 2*c] = flt_nl[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= STAT_W'(1);
            pin_q  <= '0;
        end else begin
            stat_q <= (stat_rd ? '0 : stat_q) | stat_set;
            pin_q  <= (fpin_rst ? '0 : pin_q) | flt_lat | flt_nl;
        end
    end

    assign stat_rdata = stat_q;
    assign fault_pin  = pin_q;

    // R11
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !(|flt_lat) && !(|flt_nl)) |=> (stat_rdata == '0));

    // R12
    pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fpin_rst) |=> ((fault_pin & $past(fault_pin)) == $past(fault_pin)));

endmodule

// File: rtl/ledss_top.sv
module ledss_top
    import ledss_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int IADJ_W   = 4,
    parameter int DAC_W    = 6,
    parameter int IADJ_MIN = 8,
    localparam int STAT_W  = 2 * NUM_CH + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mode_hi,
    input  logic [NUM_CH-1:0]        ch_en,
    input  logic [NUM_CH*IADJ_W-1:0] iadj,
    input  logic [NUM_CH-1:0]        comp_low,
    input  logic [NUM_CH-1:0]        pwm,
    input  logic [NUM_CH-1:0]        flt_lat,
    input  logic [NUM_CH-1:0]        flt_nl,
    input  logic                     stat_rd,
    input  logic                     fpin_rst,
    output logic [NUM_CH*DAC_W-1:0]  dac_code,
    output logic [NUM_CH-1:0]        ch_on,
    output logic [NUM_CH-1:0]        ramp_done,
    output logic [NUM_CH-1:0]        comp_pull_low,
    output logic [NUM_CH-1:0]        en_clr_req,
    output logic [NUM_CH-1:0]        fault_pin,
    output logic [STAT_W-1:0]        stat_rdata
);
    localparam logic [DAC_W-1:0] FULL = '1;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic             r_clr, r_inc, r_last;
        logic [DAC_W-1:0] r_code;
        ledss_flags_t     flg;

        ledss_ramp #(.DAC_W(DAC_W)) u_ramp (
            .clk  (clk),
            .rst  (rst),
            .clr  (r_clr),
            .inc  (r_inc),
            .code (r_code),
            .last (r_last)
        );

        ledss_fsm #(.IADJ_W(IADJ_W), .IADJ_MIN(IADJ_MIN)) u_fsm (
            .clk       (clk),
            .rst       (rst),
            .mode_hi   (mode_hi),
            .ch_en     (ch_en[c]),
            .iadj      (iadj[c*IADJ_W +: IADJ_W]),
            .comp_low  (comp_low[c]),
            .pwm       (pwm[c]),
            .flt_lat   (flt_lat[c]),
            .flt_nl    (flt_nl[c]),
            .ramp_last (r_last),
            .ramp_clr  (r_clr),
            .ramp_inc  (r_inc),
            .flags     (flg)
        );

        assign dac_code[c*DAC_W +: DAC_W] = r_code;
        assign ch_on[c]         = flg.on;
        assign ramp_done[c]     = flg.done;
        assign comp_pull_low[c] = flg.pull_low;
        assign en_clr_req[c]    = flg.clr_req;

        // R5
        done_full_chk: assert property (@(posedge clk) disable iff (rst)
            flg.done |-> (r_code == FULL));

        // R1
        idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !flg.on |-> (r_code == '0));
    end

    ledss_fault_reg #(.NUM_CH(NUM_CH)) u_flt (
        .clk        (clk),
        .rst        (rst),
        .flt_lat    (flt_lat),
        .flt_nl     (flt_nl),
        .stat_rd    (stat_rd),
        .fpin_rst   (fpin_rst),
        .stat_rdata (stat_rdata),
        .fault_pin  (fault_pin)
    );

endmodule

// File: tb/tb_ledss_top.sv
module tb_ledss_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_hi = 1'b0;
    logic [1:0] ch_en = '0;
    logic [7:0] iadj = '0;
    logic [1:0] comp_low = '0;
    logic [1:0] pwm = '0;
    logic [1:0] flt_lat = '0;
    logic [1:0] flt_nl = '0;
    logic       stat_rd = 1'b0;
    logic       fpin_rst = 1'b0;
    logic [11:0] dac_code;
    logic [1:0] ch_on, ramp_done, comp_pull_low, en_clr_req, fault_pin;
    logic [4:0] stat_rdata;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ledss_top dut (
        .clk(clk), .rst(rst), .mode_hi(mode_hi), .ch_en(ch_en), .iadj(iadj),
        .comp_low(comp_low), .pwm(pwm), .flt_lat(flt_lat), .flt_nl(flt_nl),
        .stat_rd(stat_rd), .fpin_rst(fpin_rst), .dac_code(dac_code),
        .ch_on(ch_on), .ramp_done(ramp_done), .comp_pull_low(comp_pull_low),
        .en_clr_req(en_clr_req), .fault_pin(fault_pin), .stat_rdata(stat_rdata)
    );

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; mode_hi = 1'b0; ch_en = '0; iadj = '0; comp_low = '0;
        pwm = '0; flt_lat = '0; flt_nl = '0; stat_rd = 1'b0; fpin_rst = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    // channel 0 from idle into ramp: two edges
    task automatic arm0();
        ch_en[0] = 1'b1; iadj[3:0] = 4'd9; comp_low[0] = 1'b1; pwm[0] = 1'b1;
        tick(2);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "ch_on", int'(ch_on), 0);
        chk("R1", "dac", int'(dac_code), 0);
        chk("R1", "flags", int'({ramp_done, comp_pull_low, en_clr_req, fault_pin}), 0);
        chk("R1", "status", int'(stat_rdata), 1);
        stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
        chk("R11", "status after read", int'(stat_rdata), 0);
    endtask

    task automatic t_idle_gate();
        do_reset();
        ch_en[0] = 1'b1; iadj[3:0] = 4'd8; comp_low[0] = 1'b1; pwm[0] = 1'b1;
        tick(3);
        chk("R2", "iadj=8 stays idle", int'(ch_on[0]), 0);
        iadj[3:0] = 4'd9; mode_hi = 1'b1;
        tick(3);
        chk("R2", "mode_hi stays idle", int'(ch_on[0]), 0);
        mode_hi = 1'b0;
        tick(1);
        chk("R2", "in check not on", int'(ch_on[0]), 0);
        tick(1);
        chk("R3", "ramp start on", int'(ch_on[0]), 1);
        chk("R3", "ramp start dac", int'(dac_code[5:0]), 0);
        tick(2);
        mode_hi = 1'b1;
        tick(1);
        chk("R10", "mode_hi stops", int'(ch_on[0]), 0);
        chk("R10", "mode_hi dac", int'(dac_code[5:0]), 0);
    endtask

    task automatic t_check_gate();
        do_reset();
        ch_en[0] = 1'b1; iadj[3:0] = 4'd12; pwm[0] = 1'b1;
        tick(3);
        chk("R3", "no comp_low", int'(ch_on[0]), 0);
        comp_low[0] = 1'b1; pwm[0] = 1'b0;
        tick(2);
        chk("R3", "no pwm", int'(ch_on[0]), 0);
        pwm[0] = 1'b1;
        tick(1);
        chk("R3", "all met", int'(ch_on[0]), 1);
        ch_en[0] = 1'b0;
        tick(1);
        chk("R10", "enable cleared", int'(ch_on[0]), 0);
    endtask

    task automatic t_ramp();
        do_reset();
        arm0();
        tick(5);
        chk("R4", "five steps", int'(dac_code[5:0]), 5);
        pwm[0] = 1'b0;
        tick(3);
        chk("R4", "held pwm low", int'(dac_code[5:0]), 5);
        pwm[0] = 1'b1;
        tick(57);
        chk("R4", "resumed", int'(dac_code[5:0]), 62);
        chk("R5", "not done yet", int'(ramp_done[0]), 0);
        tick(1);
        chk("R5", "full scale", int'(dac_code[5:0]), 63);
        chk("R5", "done", int'(ramp_done[0]), 1);
        pwm[0] = 1'b0;
        tick(3);
        chk("R5", "steady code", int'(dac_code[5:0]), 63);
        chk("R5", "steady on", int'(ch_on[0]), 1);
        ch_en[0] = 1'b0;
        tick(1);
        chk("R10", "done cleared", int'({ramp_done[0], dac_code[5:0]}), 0);
    endtask

    task automatic t_latched();
        do_reset();
        arm0();
        tick(4);
        flt_lat[0] = 1'b1;
        tick(1);
        flt_lat[0] = 1'b0;
        chk("R6", "off", int'(ch_on[0]), 0);
        chk("R6", "dac", int'(dac_code[5:0]), 0);
        chk("R6", "pull low", int'(comp_pull_low[0]), 1);
        chk("R6", "clr req", int'(en_clr_req[0]), 1);
        chk("R12", "pin set", int'(fault_pin[0]), 1);
        tick(1);
        chk("R6", "clr req one cycle", int'(en_clr_req[0]), 0);
        chk("R6", "via idle not on", int'(ch_on[0]), 0);
        chk("R6", "pull low held", int'(comp_pull_low[0]), 1);
        tick(1);
        chk("R6", "restarted", int'(ch_on[0]), 1);
        chk("R6", "pull low released", int'(comp_pull_low[0]), 0);
        ch_en[0] = 1'b0; tick(1);
        ch_en[0] = 1'b1; pwm[0] = 1'b0;
        tick(1);
        flt_lat[0] = 1'b1;
        tick(1);
        flt_lat[0] = 1'b0;
        chk("R6", "check-state clr req", int'(en_clr_req[0]), 1);
    endtask

    task automatic t_nonlatched();
        do_reset();
        ch_en[0] = 1'b1; iadj[3:0] = 4'd9;
        tick(1);
        comp_low[0] = 1'b1; pwm[0] = 1'b1; flt_nl[0] = 1'b1;
        tick(3);
        chk("R7", "waits in check", int'(ch_on[0]), 0);
        chk("R7", "no pull low", int'(comp_pull_low[0]), 0);
        flt_nl[0] = 1'b0;
        tick(1);
        chk("R7", "starts after clear", int'(ch_on[0]), 1);
        tick(3);
        flt_nl[0] = 1'b1;
        tick(1);
        flt_nl[0] = 1'b0;
        chk("R8", "off", int'(ch_on[0]), 0);
        chk("R8", "dac", int'(dac_code[5:0]), 0);
        chk("R8", "pull low", int'(comp_pull_low[0]), 1);
        chk("R8", "no clr req", int'(en_clr_req[0]), 0);
        tick(1);
        chk("R8", "back in check", int'(ch_on[0]), 1);
    endtask

    task automatic t_both();
        do_reset();
        arm0();
        tick(2);
        flt_lat[0] = 1'b1; flt_nl[0] = 1'b1;
        tick(1);
        flt_lat[0] = 1'b0; flt_nl[0] = 1'b0;
        chk("R9", "latched wins clr req", int'(en_clr_req[0]), 1);
        tick(1);
        chk("R9", "went to idle", int'(ch_on[0]), 0);
        tick(1);
        chk("R9", "restart after idle", int'(ch_on[0]), 1);
    endtask

    task automatic t_status();
        do_reset();
        stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
        flt_nl[1] = 1'b1;
        tick(1);
        flt_nl[1] = 1'b0;
        chk("R11", "ch1 nonlatched bit4", int'(stat_rdata), 16);
        chk("R12", "pin ch1", int'(fault_pin), 2);
        stat_rd = 1'b1; flt_lat[0] = 1'b1;
        tick(1);
        stat_rd = 1'b0; flt_lat[0] = 1'b0;
        chk("R11", "read with new fault", int'(stat_rdata), 2);
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
        chk("R11", "cleared", int'(stat_rdata), 0);
        tick(2);
        chk("R12", "pins held", int'(fault_pin), 3);
        fpin_rst = 1'b1;
        tick(1);
        fpin_rst = 1'b0;
        chk("R12", "pins cleared", int'(fault_pin), 0);
    endtask

    task automatic t_indep();
        do_reset();
        arm0();
        iadj[7:4] = 4'd15;
        tick(3);
        chk("R13", "ch_on pattern", int'(ch_on), 1);
        chk("R13", "ch1 dac", int'(dac_code[11:6]), 0);
        flt_lat[1] = 1'b1;
        tick(1);
        flt_lat[1] = 1'b0;
        chk("R13", "ch0 unaffected", int'(dac_code[5:0]), 4);
        chk("R13", "no clr req idle", int'(en_clr_req), 0);
        chk("R13", "ch0 still on", int'(ch_on[0]), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_gate();
        t_check_gate();
        t_ramp();
        t_latched();
        t_nonlatched();
        t_both();
        t_status();
        t_indep();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule